// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Generation

This block is the arithmetic and logic core of an 8-bit accumulator machine. Each operation takes an operation code, the accumulator value, a second operand and the current flag byte. It returns a new result byte and a new flag byte. One extra operation adds two 16-bit register-pair values. The core is combinational. A thin registered shell captures one operation each time the input strobe is high and presents the result one clock later.

The operations are add, add with carry, subtract, subtract with borrow, compare, negate, increment, decrement, AND, OR, XOR, complement, decimal adjust, set carry, complement carry and the 16-bit pair add. Half-carry is taken from bit 3, or from bit 11 in the pair add. Signed overflow shares a flag bit with parity. Compare leaves the accumulator unchanged. Increment and decrement keep the incoming carry.

The shell has two states. ST_IDLE means no result is being presented. ST_SHOW means `valid_o` is high and the outputs hold the result of the previous strobe. The transitions are:
- IDLE_TO_SHOW when the strobe is high in ST_IDLE.
- SHOW_STAY when the strobe is high in ST_SHOW, for back-to-back operations.
- SHOW_TO_IDLE when the strobe is low in ST_SHOW.
- IDLE_STAY when the strobe is low in ST_IDLE.

Top module: `acc_alu8`

## Requirements
- R1: Flag byte layout: sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract (N) at bit 1, carry at bit 0. Bits 5 and 3 of `flags_o` are always 0, whatever `flags_i` holds.
- R2: Opcodes 0x0 (add) and 0x1 (add with carry) work as follows.
  - H is the carry out of the low nibble. V is set when both operands have the same sign and the result sign differs. N=0.
  - Add with carry runs two steps: A plus incoming C, then that sum plus the operand. C and H are the OR of the two steps. V is the XOR of the two steps.
- R3: Opcodes 0x2 (subtract), 0x3 (subtract with borrow: A minus operand, then minus incoming C) and 0x5 (negate: 0 minus A) work as follows.
  - H is set when the low nibble of the minuend is smaller than the low nibble of the subtrahend.
  - V is set when the operand signs differ and the result sign differs from the minuend sign.
  - C is the borrow. N=1.
  - The two-step combine is the same as in R2.
- R4: Opcode 0x4 (compare) sets flags exactly as subtract does, and `res_o` equals the unchanged accumulator.
- R5: Opcode 0x6 (increment, N=0) and opcode 0x7 (decrement, N=1) set S, Z, H and V from the one-step result, and carry out of `flags_o` bit 0 equals incoming bit 0.
- R6: Opcodes 0x8, 0x9 and 0xA (AND, OR, XOR) set S and Z from the result, set bit 2 to 1 when the result has an even number of ones, and clear C and N. H is 1 for AND and 0 for OR and XOR.
- R7: Opcodes 0xB, 0xD and 0xE work as follows; S, Z and P/V are kept in all three.
  - 0xB complements A, sets H and N, and also keeps C.
  - 0xD sets C and clears H and N.
  - 0xE copies the old C into H, inverts C and clears N.
- R8: Opcode 0xC (decimal adjust) works in two stages.
  - First, 0x06 is added if the low nibble is above 9 or H is set; H is the carry out of that low-nibble add.
  - Then, 0x60 is added if the upper nibble of the corrected value is above 9 or C is set. C is 1 exactly when this second correction is applied.
  - S, Z and parity come from the final value, and N is kept.
- R9: Opcode 0xF adds `pair_a_i` and `pair_b_i` into `pair_res_o`.
  - H is the carry out of bit 11 and C is the carry out of bit 15. N is cleared. S, Z and P/V are kept.
  - `res_o` equals the accumulator.
  - For every other opcode `pair_res_o` equals `pair_a_i`.
- R10: The outputs load only on a clock edge where `valid_i` is high, and `valid_o` is high in exactly the cycle after such an edge. With the strobe held high, every cycle yields a new result.
- R11: While `rst_n` is low, `valid_o`, `res_o`, `pair_res_o` and `flags_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opd_i | input | 8 | Second operand |
| flags_i | input | 8 | Incoming flag byte |
| pair_a_i | input | 16 | First register-pair value |
| pair_b_i | input | 16 | Second register-pair value |
| valid_o | output | 1 | Result presented |
| res_o | output | 8 | Result byte |
| pair_res_o | output | 16 | 16-bit result |
| flags_o | output | 8 | New flag byte |

## Verification
Two things can fall in the same cycle. In ST_SHOW the shell presents one result while it captures the next operation. Inside the arithmetic path, a two-step carry or borrow combine can coincide with a sign flip. The bench drives the whole vector table with the strobe held high, so each result is judged in its own cycle while the next one is being captured. It also includes vectors where the first step overflows and the second step overflows back, and checks that V cancels while C and H remain set.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;
    localparam int DW    = 8;
    localparam int NIB   = 4;
    localparam int PW    = 2 * DW;
    localparam int PNIB  = PW - NIB;

    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_H  = 4;
    localparam int FB_PV = 2;
    localparam int FB_N  = 1;
    localparam int FB_C  = 0;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0, OP_ADC  = 4'h1, OP_SUB  = 4'h2, OP_SBC  = 4'h3,
        OP_CMP  = 4'h4, OP_NEG  = 4'h5, OP_INC  = 4'h6, OP_DEC  = 4'h7,
        OP_AND  = 4'h8, OP_OR   = 4'h9, OP_XOR  = 4'hA, OP_CPL  = 4'hB,
        OP_DAA  = 4'hC, OP_SCF  = 4'hD, OP_CCF  = 4'hE, OP_ADDW = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic          c;
        logic          v;
        logic          h;
        logic [DW-1:0] r;
    } step_t;

    function automatic step_t add_step(input logic [DW-1:0] x, input logic [DW-1:0] y);
        step_t      o;
        logic [DW:0]  s;
        logic [NIB:0] lo;
        s    = {1'b0, x} + {1'b0, y};
        lo   = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]};
        o.r  = s[DW-1:0];
        o.c  = s[DW];
        o.h  = lo[NIB];
        o.v  = (x[DW-1] == y[DW-1]) && (o.r[DW-1] != x[DW-1]);
        return o;
    endfunction

    function automatic step_t sub_step(input logic [DW-1:0] x, input logic [DW-1:0] y);
        step_t o;
        o.r = x - y;
        o.c = (x < y);
        o.h = (x[NIB-1:0] < y[NIB-1:0]);
        o.v = (x[DW-1] != y[DW-1]) && (o.r[DW-1] != x[DW-1]);
        return o;
    endfunction

    function automatic logic [DW-1:0] pack_flags(input logic s, input logic z, input logic h,
                                                 input logic pv, input logic n, input logic c);
        logic [DW-1:0] o;
        o        = '0;
        o[FB_S]  = s;
        o[FB_Z]  = z;
        o[FB_H]  = h;
        o[FB_PV] = pv;
        o[FB_N]  = n;
        o[FB_C]  = c;
        return o;
    endfunction
endpackage

// File: rtl/acc_alu8_addsub.sv
module acc_alu8_addsub
    import acc_alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic [DW-1:0] flags
);
    localparam logic [DW-1:0] ONE = DW'(1);

    step_t s1, s2, st;
    logic  n;
    logic [DW-1:0] cinx;

    assign cinx = {{(DW-1){1'b0}}, cin};

    always_comb begin
        s1 = add_step(a, b);
        s2 = s1;
        st = s1;
        n  = 1'b0;
        case (op)
            OP_ADD: st = add_step(a, b);
            OP_ADC: begin
                // two chained steps: carry first, then operand (R2)
                s1   = add_step(a, cinx);
                s2   = add_step(s1.r, b);
                st.r = s2.r;
                st.c = s1.c | s2.c;
                st.h = s1.h | s2.h;
                st.v = s1.v ^ s2.v;
            end
            OP_SUB, OP_CMP: begin
                st = sub_step(a, b);
                n  = 1'b1;
            end
            OP_SBC: begin
                s1   = sub_step(a, b);
                s2   = sub_step(s1.r, cinx);
                st.r = s2.r;
                st.c = s1.c | s2.c;
                st.h = s1.h | s2.h;
                st.v = s1.v ^ s2.v;
                n    = 1'b1;
            end
            OP_NEG: begin
                st = sub_step('0, a);
                n  = 1'b1;
            end
            OP_INC: begin
                st   = add_step(a, ONE);
                st.c = cin;
            end
            OP_DEC: begin
                st   = sub_step(a, ONE);
                st.c = cin;
                n    = 1'b1;
            end
            default: st = add_step(a, b);
        endcase
    end

    assign res   = (op == OP_CMP) ? a : st.r;
    assign flags = pack_flags(st.r[DW-1], st.r == '0, st.h, st.v, n, st.c);
endmodule

// File: rtl/acc_alu8_bitwise.sv
module acc_alu8_bitwise
    import acc_alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] fin,
    output logic [DW-1:0] res,
    output logic [DW-1:0] flags
);
    localparam logic [DW-1:0] KEEP_SZP  = pack_flags(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    localparam logic [DW-1:0] KEEP_SZPC = pack_flags(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    localparam logic [DW-1:0] KEEP_N    = pack_flags(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    localparam logic [DW-1:0] LOW_LIM   = DW'(9);
    localparam logic [DW-1:0] LOW_FIX   = DW'(6);
    localparam logic [DW-1:0] HIGH_FIX  = LOW_FIX << NIB;

    logic [DW-1:0] r, nf, keep;
    logic [NIB:0]  lo;
    logic          hc, cc;

    always_comb begin
        r    = a;
        nf   = '0;
        keep = '0;
        lo   = '0;
        hc   = 1'b0;
        cc   = 1'b0;
        case (op)
            OP_AND: begin
                r  = a & b;
                nf = pack_flags(r[DW-1], r == '0, 1'b1, ~^r, 1'b0, 1'b0);
            end
            OP_OR: begin
                r  = a | b;
                nf = pack_flags(r[DW-1], r == '0, 1'b0, ~^r, 1'b0, 1'b0);
            end
            OP_XOR: begin
                r  = a ^ b;
                nf = pack_flags(r[DW-1], r == '0, 1'b0, ~^r, 1'b0, 1'b0);
            end
            OP_CPL: begin
                r    = ~a;
                keep = KEEP_SZPC;
                nf   = pack_flags(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
            end
            OP_SCF: begin
                keep = KEEP_SZP;
                nf   = pack_flags(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            end
            OP_CCF: begin
                keep = KEEP_SZP;
                nf   = pack_flags(1'b0, 1'b0, fin[FB_C], 1'b0, 1'b0, ~fin[FB_C]);
            end
            OP_DAA: begin
                // low correction first, then high check on the corrected value (R8)
                if ((DW'(a[NIB-1:0]) > LOW_LIM) || fin[FB_H]) begin
                    lo = {1'b0, a[NIB-1:0]} + {1'b0, LOW_FIX[NIB-1:0]};
                    hc = lo[NIB];
                    r  = a + LOW_FIX;
                end
                if ((DW'(r[DW-1:NIB]) > LOW_LIM) || fin[FB_C]) begin
                    r  = r + HIGH_FIX;
                    cc = 1'b1;
                end
                keep = KEEP_N;
                nf   = pack_flags(r[DW-1], r == '0, hc, ~^r, 1'b0, cc);
            end
            default: r = a;
        endcase
    end

    assign res   = r;
    assign flags = (fin & keep) | nf;
endmodule

// File: rtl/acc_alu8_pair.sv
module acc_alu8_pair #(
    parameter int PAIR_W = 16,
    parameter int HC_BIT = 12
) (
    input  logic [PAIR_W-1:0] x,
    input  logic [PAIR_W-1:0] y,
    output logic [PAIR_W-1:0] sum,
    output logic              hc,
    output logic              co
);
    logic [PAIR_W:0] s;
    logic [HC_BIT:0] lo;

    assign s   = {1'b0, x} + {1'b0, y};
    assign lo  = {1'b0, x[HC_BIT-1:0]} + {1'b0, y[HC_BIT-1:0]};
    assign sum = s[PAIR_W-1:0];
    assign co  = s[PAIR_W];
    assign hc  = lo[HC_BIT];
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import acc_alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opd_i,
    input  logic [DW-1:0] flags_i,
    input  logic [PW-1:0] pair_a_i,
    input  logic [PW-1:0] pair_b_i,
    output logic          valid_o,
    output logic [DW-1:0] res_o,
    output logic [PW-1:0] pair_res_o,
    output logic [DW-1:0] flags_o
);
    typedef enum logic {ST_IDLE = 1'b0, ST_SHOW = 1'b1} state_e;

    localparam logic [DW-1:0] KEEP_PAIR = pack_flags(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

    alu_op_e       op;
    state_e        state_q, state_d;
    logic [DW-1:0] ar_res, ar_flags, bw_res, bw_flags;
    logic [PW-1:0] pr_sum;
    logic          pr_hc, pr_co;
    logic [DW-1:0] res_d, flags_d;
    logic [PW-1:0] pair_d;
    logic [DW-1:0] res_q, flags_q;
    logic [PW-1:0] pair_q;

    assign op = alu_op_e'(op_i);

    acc_alu8_addsub u_arith (
        .op(op), .a(acc_i), .b(opd_i), .cin(flags_i[FB_C]),
        .res(ar_res), .flags(ar_flags)
    );

    acc_alu8_bitwise u_bits (
        .op(op), .a(acc_i), .b(opd_i), .fin(flags_i),
        .res(bw_res), .flags(bw_flags)
    );

    acc_alu8_pair #(.PAIR_W(PW), .HC_BIT(PNIB)) u_pair (
        .x(pair_a_i), .y(pair_b_i), .sum(pr_sum), .hc(pr_hc), .co(pr_co)
    );

    always_comb begin
        pair_d = pair_a_i;
        if (op == OP_ADDW) begin
            res_d   = acc_i;
            pair_d  = pr_sum;
            flags_d = (flags_i & KEEP_PAIR)
                    | pack_flags(1'b0, 1'b0, pr_hc, 1'b0, 1'b0, pr_co);
        end else if (op <= OP_DEC) begin
            res_d   = ar_res;
            flags_d = ar_flags;
        end else begin
            res_d   = bw_res;
            flags_d = bw_flags;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = valid_i ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = valid_i ? ST_SHOW : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
            pair_q  <= '0;
        end else if (valid_i) begin
            res_q   <= res_d;
            flags_q <= flags_d;
            pair_q  <= pair_d;
        end
    end

    assign valid_o    = (state_q == ST_SHOW);
    assign res_o      = res_q;
    assign flags_o    = flags_q;
    assign pair_res_o = pair_q;

    p_spare_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (flags_o[5] == 1'b0 && flags_o[3] == 1'b0));

    p_cmp_keeps_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_CMP) |=> (res_o == $past(acc_i)));

    p_incdec_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op == OP_INC || op == OP_DEC)) |=> (flags_o[FB_C] == $past(flags_i[FB_C])));

    p_and_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_AND) |=> (flags_o[FB_H] && !flags_o[FB_C] && !flags_o[FB_N]));

    p_pair_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op == OP_ADDW) |=> (flags_o[FB_S] == $past(flags_i[FB_S])
                                     && flags_o[FB_Z] == $past(flags_i[FB_Z])
                                     && flags_o[FB_PV] == $past(flags_i[FB_PV])
                                     && !flags_o[FB_N]));

    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && $stable(res_o) && $stable(flags_o) && $stable(pair_res_o)));
endmodule

// File: tb/sim_acc_alu8.sv
module sim_acc_alu8;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [7:0]  acc_i = '0, opd_i = '0, flags_i = '0;
    logic [15:0] pair_a_i = 16'h1234, pair_b_i = 16'h1111;
    logic        valid_o;
    logic [7:0]  res_o, flags_o;
    logic [15:0] pair_res_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    acc_alu8 u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .acc_i(acc_i), .opd_i(opd_i), .flags_i(flags_i),
        .pair_a_i(pair_a_i), .pair_b_i(pair_b_i),
        .valid_o(valid_o), .res_o(res_o), .pair_res_o(pair_res_o), .flags_o(flags_o)
    );

    // {req, op, acc, operand, flags_in, expected result, expected flags}
    localparam int NV = 31;
    localparam logic [47:0] VEC [NV] = '{
        48'h2_0_0F_01_00_10_10,  // R2 half-carry
        48'h2_0_7F_01_00_80_94,  // R2 overflow
        48'h2_0_FF_01_00_00_51,  // R2 carry and zero
        48'h2_1_0F_00_01_10_10,  // R2 carry-in makes half-carry
        48'h2_1_7F_80_01_00_51,  // R2 overflows cancel, C and H kept
        48'h3_2_10_01_00_0F_12,  // R3
        48'h3_2_80_01_00_7F_16,  // R3 overflow
        48'h3_2_00_01_00_FF_93,  // R3 borrow
        48'h3_3_00_00_01_FF_93,  // R3 borrow from second step
        48'h3_3_80_00_01_7F_16,  // R3 overflow from second step
        48'h4_4_42_42_00_42_42,  // R4 equal
        48'h4_4_10_20_00_10_83,  // R4 less
        48'h3_5_01_00_00_FF_93,  // R3 negate
        48'h3_5_80_00_00_80_87,  // R3 negate of most negative
        48'h5_6_7F_00_01_80_95,  // R5 carry kept set
        48'h5_6_FF_00_00_00_50,  // R5 wrap without carry
        48'h5_7_80_00_00_7F_16,  // R5
        48'h5_7_00_00_01_FF_93,  // R5 wrap keeps carry
        48'h5_7_01_00_00_00_42,  // R5 zero
        48'h6_8_F0_0F_FF_00_54,  // R6 and
        48'h6_9_01_02_FF_03_04,  // R6 or
        48'h6_A_FF_7F_FF_80_80,  // R6 xor odd parity
        48'h1_B_5A_00_ED_A5_D7,  // R1 spare bits dropped, R7 complement
        48'h1_0_01_01_28_02_00,  // R1 spare bits dropped on add
        48'h7_D_33_00_12_33_01,  // R7 set carry
        48'h7_E_00_00_01_00_10,  // R7 complement carry
        48'h7_E_00_00_12_00_01,  // R7 complement carry from clear
        48'h8_C_0A_00_00_10_10,  // R8 low fix
        48'h8_C_9A_00_00_00_55,  // R8 both fixes
        48'h8_C_15_00_01_75_01,  // R8 carry forces high fix
        48'h8_C_00_00_02_00_46   // R8 N kept
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] f);
        op_i    = op;
        acc_i   = a;
        opd_i   = b;
        flags_i = f;
        valid_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 valid", {15'b0, valid_o}, 16'h0);
        chk("R11 res", {8'b0, res_o}, 16'h0);
        chk("R11 flags", {8'b0, flags_o}, 16'h0);
        chk("R11 pair", pair_res_o, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walked back to back with the strobe held high (R10)
        drive(VEC[0][43:40], VEC[0][39:32], VEC[0][31:24], VEC[0][23:16]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            chk($sformatf("R%0d vec%0d valid", VEC[i][47:44], i), {15'b0, valid_o}, 16'h1);
            chk($sformatf("R%0d vec%0d res", VEC[i][47:44], i), {8'b0, res_o}, {8'b0, VEC[i][15:8]});
            chk($sformatf("R%0d vec%0d flags", VEC[i][47:44], i), {8'b0, flags_o}, {8'b0, VEC[i][7:0]});
            if (i + 1 < NV)
                drive(VEC[i+1][43:40], VEC[i+1][39:32], VEC[i+1][31:24], VEC[i+1][23:16]);
        end
        // R9: pair result passes pair_a for a byte operation
        chk("R9 pair passthrough", pair_res_o, 16'h1234);

        // R10: strobe low, inputs change, outputs hold
        valid_i = 1'b0;
        drive(4'h0, 8'h11, 8'h22, 8'h00);
        valid_i = 1'b0;
        @(negedge clk);
        chk("R10 valid drops", {15'b0, valid_o}, 16'h0);
        chk("R10 res held", {8'b0, res_o}, 16'h0000);
        chk("R10 flags held", {8'b0, flags_o}, 16'h0046);
        @(negedge clk);
        chk("R10 still idle", {15'b0, valid_o}, 16'h0);

        // R9 pair add cases
        pair_a_i = 16'h0FFF; pair_b_i = 16'h0001;
        drive(4'hF, 8'h5C, 8'h00, 8'hC6);
        @(negedge clk);
        valid_i = 1'b0;
        chk("R9 sum", pair_res_o, 16'h1000);
        chk("R9 flags bit11", {8'b0, flags_o}, 16'h00D4);
        chk("R9 acc kept", {8'b0, res_o}, 16'h005C);
        pair_a_i = 16'hFFFF; pair_b_i = 16'h0001;
        drive(4'hF, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        valid_i = 1'b0;
        chk("R9 wrap sum", pair_res_o, 16'h0000);
        chk("R9 wrap flags no zero", {8'b0, flags_o}, 16'h0011);
        pair_a_i = 16'h8000; pair_b_i = 16'h8000;
        drive(4'hF, 8'h00, 8'h00, 8'h04);
        @(negedge clk);
        valid_i = 1'b0;
        chk("R9 top carry", {8'b0, flags_o}, 16'h0005);

        // R11: reset mid-run clears outputs
        rst_n = 1'b0;
        #1;
        chk("R11 async valid", {15'b0, valid_o}, 16'h0);
        chk("R11 async flags", {8'b0, flags_o}, 16'h0);
        chk("R11 async pair", pair_res_o, 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule